// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the addressing-mode field of an instruction into an operand address. It works for a machine with eight 32-bit address registers and 16-bit extension words. The caller supplies the following:

- the mode code, the register number and the operand size;
- the flattened address-register file;
- an index value that the caller has already selected and sized;
- the address of the opcode word;
- up to two extension words.

One clock later the unit returns these results:

- the effective address;
- an optional write-back of the updated address register for the auto-increment and auto-decrement modes;
- the number of extension words the mode consumed;
- an immediate operand, where the mode has one;
- a flag that separates program-space references from data-space references.

The unit has a single registered output stage. A result is produced for every cycle in which `in_valid` is high. In a cycle with `in_valid` low, `out_valid` and `wb_en` fall and every other output keeps its last value. The unit does not fetch instructions, access memory, decode the opcode, or decode index fields inside an extension word.

Top module: `ea_gen_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls if `in_valid` was low, `out_valid` and `wb_en` are 0.
- R2: Mode code 0 (register indirect): `ea_addr` equals register `reg_sel`, `ext_used` is 0, `wb_en` is 0 and `prog_ref` is 0.
- R3: Mode code 1 (post-increment): `ea_addr` equals the register value before the update. `wb_en` is 1, `wb_reg` equals `reg_sel`, and `wb_val` equals the register plus the step. The step is 1 for size code 0 (byte), 2 for size code 1 (word), and 4 for size code 2 or 3 (long). `ext_used` is 0.
- R4: Mode code 2 (pre-decrement): `wb_en` is 1, `wb_reg` equals `reg_sel`, and both `wb_val` and `ea_addr` equal the register minus the step defined in R3. `ext_used` is 0.
- R5: When `reg_sel` is 7 (the stack pointer) and the size is byte, the step of both post-increment and pre-decrement is 2 instead of 1. Word and long steps are unchanged.
- R6: Mode code 3 (displacement): `ea_addr` is the register plus `ext_w0` sign-extended from 16 bits, and `ext_used` is 1.
- R7: Mode code 4 (indexed): `ea_addr` is the register plus `index_val` plus bits 7:0 of `ext_w0` sign-extended. Bits 15:8 of `ext_w0` have no effect. `ext_used` is 1.
- R8: Mode code 5 (absolute short): `ea_addr` is `ext_w0` sign-extended, with `ext_used` 1. Mode code 6 (absolute long): `ea_addr` is `{ext_w0, ext_w1}`, with `ext_used` 2.
- R9: Modes 7 (PC plus displacement) and 8 (PC plus index) use `pc_in + 2`, the address of the first extension word, as the base. Mode 7 adds the sign-extended `ext_w0`. Mode 8 adds `index_val` and the sign-extended `ext_w0[7:0]`. Both have `ext_used` 1 and `prog_ref` 1. Every other mode gives `prog_ref` 0.
- R10: Mode code 9 (immediate): `ea_addr` is 0. A byte gives `imm_val` = `ext_w0[7:0]` zero-extended, with `ext_used` 1. A word gives `ext_w0` zero-extended, with `ext_used` 1. A long gives `{ext_w0, ext_w1}`, with `ext_used` 2. In every other mode `imm_val` is 0.
- R11: Each output reflects the inputs of the cycle one rising edge earlier, and `out_valid` equals the previous cycle's `in_valid`. After a cycle with `in_valid` low, `ea_addr`, `ext_used`, `imm_val` and `prog_ref` keep their previous values.
- R12: `wb_en` is 1 only when `out_valid` is 1 and the mode was 1 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request in this cycle |
| mode_in | input | 4 | Addressing-mode code (0 to 9) |
| reg_sel | input | 3 | Address register number |
| size_in | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| areg_flat | input | 256 | Register n in bits n*32+31 down to n*32 |
| index_val | input | 32 | Selected and sized index value |
| pc_in | input | 32 | Address of the opcode word |
| ext_w0 | input | 16 | First extension word |
| ext_w1 | input | 16 | Second extension word |
| out_valid | output | 1 | Result valid |
| ea_addr | output | 32 | Effective address |
| wb_en | output | 1 | Register write-back enable |
| wb_reg | output | 3 | Register to update |
| wb_val | output | 32 | Updated register value |
| ext_used | output | 2 | Extension words consumed |
| imm_val | output | 32 | Immediate operand |
| prog_ref | output | 1 | 1 for a program-space reference |

## Verification
Every result is due exactly one rising edge after the cycle in which its request is presented. Idle cycles are due on the same edge, with `out_valid` and `wb_en` low and the other outputs held. The driver applies one request or one idle slot per falling edge and queues the outputs expected from the requirements. The monitor takes one entry from the queue 1 ns after each rising edge and compares it with the outputs, so each comparison falls in the cycle its result is registered. `wb_val` and `wb_reg` are compared only when a write-back is expected.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [3:0] {
    EA_AIND     = 4'd0,
    EA_POSTINC  = 4'd1,
    EA_PREDEC   = 4'd2,
    EA_DISP     = 4'd3,
    EA_INDEX    = 4'd4,
    EA_ABSW     = 4'd5,
    EA_ABSL     = 4'd6,
    EA_PCDISP   = 4'd7,
    EA_PCINDEX  = 4'd8,
    EA_IMM      = 4'd9
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONG2 = 2'd3
  } ea_size_e;

endpackage

// File: rtl/ea_step_sel.sv
module ea_step_sel
  import ea_gen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RSW    = 3,
  parameter int SP_IDX = 7
) (
  input  ea_size_e        size_i,
  input  logic [RSW-1:0]  reg_i,
  output logic [AW-1:0]   step_o
);

  localparam logic [RSW-1:0] SP_CODE = RSW'(SP_IDX);

  always_comb begin
    case (size_i)
      SZ_BYTE: step_o = (reg_i == SP_CODE) ? AW'(2) : AW'(1);
      SZ_WORD: step_o = AW'(2);
      default: step_o = AW'(4);
    endcase
  end

endmodule

// File: rtl/ea_addr_core.sv
module ea_addr_core
  import ea_gen_pkg::*;
#(
  parameter int AW   = 32,
  parameter int EXTW = 16,
  parameter int NREG = 8,
  parameter int RSW  = $clog2(NREG)
) (
  input  ea_mode_e            mode_i,
  input  ea_size_e            size_i,
  input  logic [RSW-1:0]      reg_i,
  input  logic [NREG*AW-1:0]  areg_i,
  input  logic [AW-1:0]       index_i,
  input  logic [AW-1:0]       pc_i,
  input  logic [EXTW-1:0]     ext0_i,
  input  logic [EXTW-1:0]     ext1_i,
  input  logic [AW-1:0]       step_i,
  output logic [AW-1:0]       ea_o,
  output logic                wb_en_o,
  output logic [AW-1:0]       wb_val_o,
  output logic [1:0]          ext_o,
  output logic [AW-1:0]       imm_o,
  output logic                prog_o
);

  localparam int EXT_BYTES = EXTW / 8;

  logic [AW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = areg_i[g*AW +: AW];
  end

  logic [AW-1:0] base;
  logic [AW-1:0] disp_w;
  logic [AW-1:0] disp_b;
  logic [AW-1:0] pc_base;
  logic [AW-1:0] long_word;

  assign base      = regs[reg_i];
  assign disp_w    = {{(AW-EXTW){ext0_i[EXTW-1]}}, ext0_i};
  assign disp_b    = {{(AW-8){ext0_i[7]}}, ext0_i[7:0]};
  assign pc_base   = pc_i + AW'(EXT_BYTES);
  assign long_word = AW'({ext0_i, ext1_i});

  always_comb begin
    ea_o     = '0;
    wb_en_o  = 1'b0;
    wb_val_o = base;
    ext_o    = 2'd0;
    imm_o    = '0;
    prog_o   = 1'b0;
    case (mode_i)
      EA_AIND: ea_o = base;
      EA_POSTINC: begin
        ea_o     = base;
        wb_en_o  = 1'b1;
        wb_val_o = base + step_i;
      end
      EA_PREDEC: begin
        ea_o     = base - step_i;
        wb_en_o  = 1'b1;
        wb_val_o = base - step_i;
      end
      EA_DISP: begin
        ea_o  = base + disp_w;
        ext_o = 2'd1;
      end
      EA_INDEX: begin
        ea_o  = base + index_i + disp_b;
        ext_o = 2'd1;
      end
      EA_ABSW: begin
        ea_o  = disp_w;
        ext_o = 2'd1;
      end
      EA_ABSL: begin
        ea_o  = long_word;
        ext_o = 2'd2;
      end
      EA_PCDISP: begin
        ea_o   = pc_base + disp_w;
        ext_o  = 2'd1;
        prog_o = 1'b1;
      end
      EA_PCINDEX: begin
        ea_o   = pc_base + index_i + disp_b;
        ext_o  = 2'd1;
        prog_o = 1'b1;
      end
      EA_IMM: begin
        case (size_i)
          SZ_BYTE: begin imm_o = AW'(ext0_i[7:0]); ext_o = 2'd1; end
          SZ_WORD: begin imm_o = AW'(ext0_i);      ext_o = 2'd1; end
          default: begin imm_o = long_word;        ext_o = 2'd2; end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg
  import ea_gen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RSW    = 3,
  parameter int SP_IDX = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  ea_mode_e        mode_i,
  input  ea_size_e        size_i,
  input  logic [RSW-1:0]  reg_i,
  input  logic [AW-1:0]   ea_i,
  input  logic            wb_en_i,
  input  logic [AW-1:0]   wb_val_i,
  input  logic [1:0]      ext_i,
  input  logic [AW-1:0]   imm_i,
  input  logic            prog_i,
  output logic            out_valid,
  output logic [AW-1:0]   ea_addr,
  output logic            wb_en,
  output logic [RSW-1:0]  wb_reg,
  output logic [AW-1:0]   wb_val,
  output logic [1:0]      ext_used,
  output logic [AW-1:0]   imm_val,
  output logic            prog_ref
);

  ea_mode_e mode_q;
  ea_size_e size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      ea_addr   <= '0;
      wb_reg    <= '0;
      wb_val    <= '0;
      ext_used  <= 2'd0;
      imm_val   <= '0;
      prog_ref  <= 1'b0;
      mode_q    <= EA_AIND;
      size_q    <= SZ_BYTE;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & wb_en_i;
      if (in_valid) begin
        ea_addr  <= ea_i;
        wb_reg   <= reg_i;
        wb_val   <= wb_val_i;
        ext_used <= ext_i;
        imm_val  <= imm_i;
        prog_ref <= prog_i;
        mode_q   <= mode_i;
        size_q   <= size_i;
      end
    end
  end

  p_valid_latency_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  p_wb_modes_r12: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (out_valid && (mode_q == EA_POSTINC || mode_q == EA_PREDEC)));

  p_predec_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == EA_PREDEC) |-> (ea_addr == wb_val));

  p_sp_byte_step_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == EA_POSTINC && size_q == SZ_BYTE && wb_reg == RSW'(SP_IDX))
      |-> (wb_val - ea_addr == AW'(2)));

  p_prog_ref_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && prog_ref) |-> (ext_used == 2'd1 &&
      (mode_q == EA_PCDISP || mode_q == EA_PCINDEX)));

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_gen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int EXTW   = 16,
  parameter int NREG   = 8,
  parameter int SP_IDX = 7,
  localparam int RSW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [3:0]          mode_in,
  input  logic [RSW-1:0]      reg_sel,
  input  logic [1:0]          size_in,
  input  logic [NREG*AW-1:0]  areg_flat,
  input  logic [AW-1:0]       index_val,
  input  logic [AW-1:0]       pc_in,
  input  logic [EXTW-1:0]     ext_w0,
  input  logic [EXTW-1:0]     ext_w1,
  output logic                out_valid,
  output logic [AW-1:0]       ea_addr,
  output logic                wb_en,
  output logic [RSW-1:0]      wb_reg,
  output logic [AW-1:0]       wb_val,
  output logic [1:0]          ext_used,
  output logic [AW-1:0]       imm_val,
  output logic                prog_ref
);

  ea_mode_e      mode_c;
  ea_size_e      size_c;
  logic [AW-1:0] step_c;
  logic [AW-1:0] ea_c;
  logic          wb_en_c;
  logic [AW-1:0] wb_val_c;
  logic [1:0]    ext_c;
  logic [AW-1:0] imm_c;
  logic          prog_c;

  assign mode_c = ea_mode_e'(mode_in);
  assign size_c = ea_size_e'(size_in);

  ea_step_sel #(.AW(AW), .RSW(RSW), .SP_IDX(SP_IDX)) u_step (
    .size_i (size_c),
    .reg_i  (reg_sel),
    .step_o (step_c)
  );

  ea_addr_core #(.AW(AW), .EXTW(EXTW), .NREG(NREG), .RSW(RSW)) u_core (
    .mode_i   (mode_c),
    .size_i   (size_c),
    .reg_i    (reg_sel),
    .areg_i   (areg_flat),
    .index_i  (index_val),
    .pc_i     (pc_in),
    .ext0_i   (ext_w0),
    .ext1_i   (ext_w1),
    .step_i   (step_c),
    .ea_o     (ea_c),
    .wb_en_o  (wb_en_c),
    .wb_val_o (wb_val_c),
    .ext_o    (ext_c),
    .imm_o    (imm_c),
    .prog_o   (prog_c)
  );

  ea_out_reg #(.AW(AW), .RSW(RSW), .SP_IDX(SP_IDX)) u_oreg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode_i    (mode_c),
    .size_i    (size_c),
    .reg_i     (reg_sel),
    .ea_i      (ea_c),
    .wb_en_i   (wb_en_c),
    .wb_val_i  (wb_val_c),
    .ext_i     (ext_c),
    .imm_i     (imm_c),
    .prog_i    (prog_c),
    .out_valid (out_valid),
    .ea_addr   (ea_addr),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .wb_val    (wb_val),
    .ext_used  (ext_used),
    .imm_val   (imm_val),
    .prog_ref  (prog_ref)
  );

endmodule

// File: tb/sim_ea_gen_unit.sv
module sim_ea_gen_unit;

  typedef struct {
    logic        v;
    logic [31:0] ea;
    logic        wb;
    logic [2:0]  wr;
    logic [31:0] wv;
    logic [1:0]  ext;
    logic [31:0] imm;
    logic        pr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  mode_in = '0;
  logic [2:0]  reg_sel = '0;
  logic [1:0]  size_in = '0;
  logic [255:0] areg_flat;
  logic [31:0] index_val = '0;
  logic [31:0] pc_in = '0;
  logic [15:0] ext_w0 = '0;
  logic [15:0] ext_w1 = '0;
  logic        out_valid;
  logic [31:0] ea_addr;
  logic        wb_en;
  logic [2:0]  wb_reg;
  logic [31:0] wb_val;
  logic [1:0]  ext_used;
  logic [31:0] imm_val;
  logic        prog_ref;

  logic [31:0] areg [8];
  exp_t        q [$];
  exp_t        last;
  int          n_checks = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_pack
    assign areg_flat[g*32 +: 32] = areg[g];
  end

  ea_gen_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_in(mode_in),
    .reg_sel(reg_sel), .size_in(size_in), .areg_flat(areg_flat),
    .index_val(index_val), .pc_in(pc_in), .ext_w0(ext_w0), .ext_w1(ext_w1),
    .out_valid(out_valid), .ea_addr(ea_addr), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_val(wb_val), .ext_used(ext_used), .imm_val(imm_val), .prog_ref(prog_ref)
  );

  function automatic exp_t model(input logic [3:0] m, input logic [2:0] r,
                                 input logic [1:0] s, input logic [31:0] idx,
                                 input logic [31:0] pc, input logic [15:0] e0,
                                 input logic [15:0] e1, input string tag);
    exp_t x;
    logic [31:0] st;
    logic [31:0] a;
    a = areg[r];
    st = (s == 2'd0) ? ((r == 3'd7) ? 32'd2 : 32'd1) : (s == 2'd1) ? 32'd2 : 32'd4;
    x.v = 1'b1; x.ea = '0; x.wb = 1'b0; x.wr = r; x.wv = '0; x.ext = 2'd0;
    x.imm = '0; x.pr = 1'b0; x.tag = tag;
    case (m)
      4'd0: x.ea = a;
      4'd1: begin x.ea = a; x.wb = 1'b1; x.wv = a + st; end
      4'd2: begin x.ea = a - st; x.wb = 1'b1; x.wv = a - st; end
      4'd3: begin x.ea = a + {{16{e0[15]}}, e0}; x.ext = 2'd1; end
      4'd4: begin x.ea = a + idx + {{24{e0[7]}}, e0[7:0]}; x.ext = 2'd1; end
      4'd5: begin x.ea = {{16{e0[15]}}, e0}; x.ext = 2'd1; end
      4'd6: begin x.ea = {e0, e1}; x.ext = 2'd2; end
      4'd7: begin x.ea = pc + 32'd2 + {{16{e0[15]}}, e0}; x.ext = 2'd1; x.pr = 1'b1; end
      4'd8: begin x.ea = pc + 32'd2 + idx + {{24{e0[7]}}, e0[7:0]}; x.ext = 2'd1; x.pr = 1'b1; end
      4'd9: begin
        if (s == 2'd0)      begin x.imm = {24'd0, e0[7:0]}; x.ext = 2'd1; end
        else if (s == 2'd1) begin x.imm = {16'd0, e0};      x.ext = 2'd1; end
        else                begin x.imm = {e0, e1};         x.ext = 2'd2; end
      end
      default: ;
    endcase
    return x;
  endfunction

  task automatic drive(input logic [3:0] m, input logic [2:0] r, input logic [1:0] s,
                       input logic [31:0] idx, input logic [31:0] pc,
                       input logic [15:0] e0, input logic [15:0] e1, input string tag);
    @(negedge clk);
    in_valid = 1'b1; mode_in = m; reg_sel = r; size_in = s;
    index_val = idx; pc_in = pc; ext_w0 = e0; ext_w1 = e1;
    last = model(m, r, s, idx, pc, e0, e1, tag);
    q.push_back(last);
  endtask

  task automatic idle(input string tag);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b0; mode_in = 4'd3; reg_sel = 3'd5; ext_w0 = 16'h7777; ext_w1 = 16'h1111;
    x = last; x.v = 1'b0; x.wb = 1'b0; x.tag = tag;
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      logic bad;
      x = q.pop_front();
      bad = (out_valid !== x.v) || (wb_en !== x.wb) || (ea_addr !== x.ea) ||
            (ext_used !== x.ext) || (imm_val !== x.imm) || (prog_ref !== x.pr) ||
            (x.wb && ((wb_val !== x.wv) || (wb_reg !== x.wr)));
      n_checks++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: act v=%b ea=%h wb=%b wr=%0d wv=%h ext=%0d imm=%h pr=%b exp v=%b ea=%h wb=%b wr=%0d wv=%h ext=%0d imm=%h pr=%b",
                 x.tag, out_valid, ea_addr, wb_en, wb_reg, wb_val, ext_used, imm_val, prog_ref,
                 x.v, x.ea, x.wb, x.wr, x.wv, x.ext, x.imm, x.pr);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    areg[0] = 32'h0000_1000; areg[1] = 32'h2000_0000; areg[2] = 32'hFFFF_FFFE;
    areg[3] = 32'h1234_5678; areg[4] = 32'h0000_0040; areg[5] = 32'hA5A5_0000;
    areg[6] = 32'h0000_0001; areg[7] = 32'h0000_8000;
    last = '{v:1'b0, ea:'0, wb:1'b0, wr:'0, wv:'0, ext:2'd0, imm:'0, pr:1'b0, tag:"R11"};
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || wb_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: act v=%b wb=%b exp v=0 wb=0", out_valid, wb_en);
    end
    @(negedge clk);
    rst = 1'b0;
    idle("R1 first cycle after reset");
    drive(4'd0, 3'd3, 2'd2, 0, 0, 16'h0, 16'h0, "R2 indirect");
    drive(4'd1, 3'd1, 2'd0, 0, 0, 16'h0, 16'h0, "R3 postinc byte");
    drive(4'd1, 3'd2, 2'd1, 0, 0, 16'h0, 16'h0, "R3 postinc word wrap");
    drive(4'd1, 3'd0, 2'd2, 0, 0, 16'h0, 16'h0, "R3 postinc long");
    drive(4'd2, 3'd0, 2'd0, 0, 0, 16'h0, 16'h0, "R4 predec byte");
    drive(4'd2, 3'd3, 2'd3, 0, 0, 16'h0, 16'h0, "R4 predec long code3");
    drive(4'd1, 3'd7, 2'd0, 0, 0, 16'h0, 16'h0, "R5 sp postinc byte");
    drive(4'd2, 3'd7, 2'd0, 0, 0, 16'h0, 16'h0, "R5 sp predec byte");
    drive(4'd1, 3'd7, 2'd1, 0, 0, 16'h0, 16'h0, "R5 sp postinc word");
    idle("R11 hold after postinc");
    idle("R12 idle no writeback");
    drive(4'd3, 3'd0, 2'd1, 0, 0, 16'hFFF0, 16'h0, "R6 negative disp");
    drive(4'd3, 3'd4, 2'd1, 0, 0, 16'h0100, 16'h0, "R6 positive disp");
    drive(4'd4, 3'd1, 2'd1, 32'h10, 0, 16'h12FE, 16'h0, "R7 index neg low byte");
    drive(4'd4, 3'd4, 2'd2, 32'hFFFF_FF00, 0, 16'hAA7F, 16'h0, "R7 index pos low byte");
    drive(4'd5, 3'd0, 2'd1, 0, 0, 16'h8000, 16'h0, "R8 abs short neg");
    drive(4'd5, 3'd0, 2'd1, 0, 0, 16'h7FFF, 16'h0, "R8 abs short pos");
    drive(4'd6, 3'd0, 2'd2, 0, 0, 16'hDEAD, 16'hBEEF, "R8 abs long");
    drive(4'd7, 3'd0, 2'd1, 0, 32'h400, 16'h0010, 16'h0, "R9 pc disp");
    drive(4'd7, 3'd0, 2'd1, 0, 32'h400, 16'hFFFC, 16'h0, "R9 pc disp neg");
    drive(4'd8, 3'd0, 2'd1, 32'h4, 32'h400, 16'h00F0, 16'h0, "R9 pc index");
    idle("R11 hold after pc ref");
    drive(4'd9, 3'd0, 2'd0, 0, 0, 16'hABCD, 16'h0, "R10 imm byte");
    drive(4'd9, 3'd0, 2'd1, 0, 0, 16'hABCD, 16'h0, "R10 imm word");
    drive(4'd9, 3'd0, 2'd2, 0, 0, 16'h1234, 16'h5678, "R10 imm long");
    idle("R11 hold after imm");
    drive(4'd2, 3'd5, 2'd1, 0, 0, 16'h0, 16'h0, "R4 predec word");
    drive(4'd3, 3'd6, 2'd0, 0, 0, 16'h0002, 16'h0, "R12 disp no writeback");
    idle("R12 tail");
    idle("R11 tail");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule